// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector

This block is the receive front end of a two-wire serial slave. It takes the clock line and the data line as plain digital levels, brings each into the system clock domain, and removes pulses shorter than a programmable width. From the two cleaned levels it produces single-cycle strobes for start conditions, stop conditions and for the rising and falling edges of the clock line. It also holds the data bit sampled at the latest clock rise. A protocol engine downstream consumes these strobes and never looks at the raw lines.

A start is recognised when the data line goes low while the clock line stays high, and a stop when the data line goes high while the clock line stays high. Both are judged against the filtered clock level from the cycle before the data edge. When the data line and the clock line change in the same filtered cycle, the result is ordinary data and never a bus condition. A master can therefore re-align a slave at any time: it releases the data line, toggles the clock nine times, and then issues a start. That start is reported like any other and is followed by a clean stop.

Top module: `twb_cond_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all four strobes and `bit_o` are 0. Both filtered lines begin at the idle (high) level.
- R2: A falling data line while the filtered clock line is high, and was high on the previous cycle, produces exactly one `start_o` pulse.
- R3: A rising data line while the filtered clock line is high, and was high on the previous cycle, produces exactly one `stop_o` pulse.
- R4: Every low-to-high change of the filtered clock line produces one `scl_rise_o` pulse. In the same cycle `bit_o` takes the filtered data level, and it keeps that value until the next clock rise.
- R5: Every high-to-low change of the filtered clock line produces one `scl_fall_o` pulse.
- R6: Data-line changes while the clock line is low produce no strobe of any kind.
- R7: A pulse on either input lasting FILT_CYCLES-1 system clocks or fewer produces no strobe. A level held for FILT_CYCLES clocks is accepted.
- R8: When the data line and the clock line change in the same cycle, only the clock edge strobe is produced, with no start or stop. A joint rise reports data bit 1.
- R9: Each strobe lasts one system clock, and at most one of the four strobes is high in any cycle.
- R10: After a start followed by nine clock pulses with the data line high, a new start is reported, and the stop that follows is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line level |
| sda_i | input | 1 | Raw serial data line level |
| start_o | output | 1 | Start condition strobe |
| stop_o | output | 1 | Stop condition strobe |
| scl_rise_o | output | 1 | Filtered clock rising-edge strobe |
| scl_fall_o | output | 1 | Filtered clock falling-edge strobe |
| bit_o | output | 1 | Data bit captured at the last clock rise |

## Verification
The hardest case to reach is the one where both lines move in the same filtered cycle. Reaching it needs identical synchroniser and filter delay on both lanes, so the stimulus changes both inputs on the same falling system-clock edge. Glitches are driven with widths just below and exactly at the filter threshold, and the limit is checked from both sides. Recovery is exercised with a start, nine dummy clock pulses with the data line released, and then a fresh start and stop.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int unsigned LANES    = 2;
  localparam int unsigned LANE_SCL = 0;
  localparam int unsigned LANE_SDA = 1;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } twb_strobe_t;
endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/twb_glitch_filt.sv
module twb_glitch_filt #(
  parameter int unsigned FILT_CYCLES = 6,
  parameter logic        RST_VAL     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW  = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (d_i == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      lvl_d = d_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/twb_cond_logic.sv
module twb_cond_logic
  import twb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_f_i,
  input  logic        sda_f_i,
  output twb_strobe_t strb_o,
  output logic        bit_o
);
  logic        scl_q, sda_q;
  twb_strobe_t strb_q, strb_d;
  logic        bit_q, bit_d;

  always_comb begin
    strb_d.start = scl_q & scl_f_i & sda_q & ~sda_f_i;
    strb_d.stop  = scl_q & scl_f_i & ~sda_q & sda_f_i;
    strb_d.rise  = ~scl_q & scl_f_i;
    strb_d.fall  = scl_q & ~scl_f_i;
    bit_d        = strb_d.rise ? sda_f_i : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      strb_q <= '0;
      bit_q  <= 1'b0;
    end else begin
      scl_q  <= scl_f_i;
      sda_q  <= sda_f_i;
      strb_q <= strb_d;
      bit_q  <= bit_d;
    end
  end

  assign strb_o = strb_q;
  assign bit_o  = bit_q;
endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect
  import twb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic bit_o
);
  logic [LANES-1:0] line_raw;
  logic [LANES-1:0] line_sync;
  logic [LANES-1:0] line_filt;
  twb_strobe_t      strb;
  logic             scl_sync, scl_filt, sda_filt;

  assign line_raw[LANE_SCL] = scl_i;
  assign line_raw[LANE_SDA] = sda_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    twb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (line_raw[g]),
      .q_o  (line_sync[g])
    );
    twb_glitch_filt #(.FILT_CYCLES(FILT_CYCLES), .RST_VAL(1'b1)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (line_sync[g]),
      .q_o  (line_filt[g])
    );
  end

  assign scl_sync = line_sync[LANE_SCL];
  assign scl_filt = line_filt[LANE_SCL];
  assign sda_filt = line_filt[LANE_SDA];

  twb_cond_logic u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_f_i(scl_filt),
    .sda_f_i(sda_filt),
    .strb_o (strb),
    .bit_o  (bit_o)
  );

  assign start_o    = strb.start;
  assign stop_o     = strb.stop;
  assign scl_rise_o = strb.rise;
  assign scl_fall_o = strb.fall;
endmodule

// File: rtl/twb_cond_detect_chk.sv
module twb_cond_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_sync,
  input logic scl_filt,
  input logic sda_filt,
  input logic start_o,
  input logic stop_o,
  input logic scl_rise_o,
  input logic scl_fall_o,
  input logic bit_o
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!start_o && !stop_o && !scl_rise_o && !scl_fall_o && !bit_o);
    end
  end

  // R2
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> ($past(scl_filt) && !$past(sda_filt) && $past(sda_filt, 2) && $past(scl_filt, 2)));

  // R3
  stop_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> ($past(scl_filt) && $past(sda_filt) && !$past(sda_filt, 2) && $past(scl_filt, 2)));

  // R4
  rise_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_o |-> (bit_o == $past(sda_filt) && $past(scl_filt) && !$past(scl_filt, 2)));

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_o) |-> scl_rise_o);

  // R5
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_o |-> (!$past(scl_filt) && $past(scl_filt, 2)));

  // R7
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_filt) |-> (scl_filt == $past(scl_sync)));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));

  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R9
  stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o);
endmodule

bind twb_cond_detect twb_cond_detect_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_sync  (scl_sync),
  .scl_filt  (scl_filt),
  .sda_filt  (sda_filt),
  .start_o   (start_o),
  .stop_o    (stop_o),
  .scl_rise_o(scl_rise_o),
  .scl_fall_o(scl_fall_o),
  .bit_o     (bit_o)
);

// File: tb/twb_cond_detect_bench.sv
module twb_cond_detect_bench;
  localparam int FILT   = 6;
  localparam int SETTLE = FILT + 8;

  localparam int EV_START = 0;
  localparam int EV_STOP  = 1;
  localparam int EV_RISE0 = 2;
  localparam int EV_RISE1 = 3;
  localparam int EV_FALL  = 4;

  typedef struct {
    int    code;
    string tag;
  } exp_t;

  logic clk;
  logic rst_n;
  logic scl_r, sda_r;
  logic start_o, stop_o, scl_rise_o, scl_fall_o, bit_o;

  exp_t exp_q[$];
  int   n_chk;
  int   n_fail;
  bit   running;
  bit   done;
  logic [3:0] prev_strb;

  twb_cond_detect #(.SYNC_STAGES(2), .FILT_CYCLES(FILT)) u_twb_cond_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_r),
    .sda_i     (sda_r),
    .start_o   (start_o),
    .stop_o    (stop_o),
    .scl_rise_o(scl_rise_o),
    .scl_fall_o(scl_fall_o),
    .bit_o     (bit_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string ev_name(input int c);
    case (c)
      EV_START: return "START";
      EV_STOP:  return "STOP";
      EV_RISE0: return "RISE0";
      EV_RISE1: return "RISE1";
      EV_FALL:  return "FALL";
      default:  return "NONE";
    endcase
  endfunction

  task automatic expect_ev(input int code, input string tag);
    exp_t e;
    e.code = code;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic drive(input logic s, input logic d, input int hold);
    @(negedge clk);
    scl_r = s;
    sda_r = d;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    repeat (SETTLE) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d expected events missing, next %s, expected none pending",
               tag, exp_q.size(), ev_name(exp_q[0].code));
      exp_q.delete();
    end
  endtask

  // Scoreboard monitor: compares each observed strobe against the queue.
  always @(negedge clk) begin
    if (rst_n && running) begin
      logic [3:0] strb;
      int         got;
      strb = {start_o, stop_o, scl_rise_o, scl_fall_o};
      if ((strb & prev_strb) != 4'b0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R9: strobe held two cycles, actual %b expected single pulse", strb);
      end
      if ($countones(strb) > 1) begin
        n_chk++;
        n_fail++;
        $display("FAIL R9: several strobes at once, actual %b expected at most one", strb);
      end else if (strb != 4'b0) begin
        got = start_o ? EV_START : stop_o ? EV_STOP :
              scl_fall_o ? EV_FALL : (bit_o ? EV_RISE1 : EV_RISE0);
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R6/R7: unexpected event, actual %s expected none", ev_name(got));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (got != e.code) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", e.tag, ev_name(got), ev_name(e.code));
          end
        end
      end
      prev_strb = strb;
    end
  end

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    running   = 1'b0;
    prev_strb = 4'b0;
    rst_n     = 1'b0;
    scl_r     = 1'b1;
    sda_r     = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet outputs during reset
    n_chk++;
    if ({start_o, stop_o, scl_rise_o, scl_fall_o, bit_o} != 5'b0) begin
      n_fail++;
      $display("FAIL R1: actual %b expected 00000", {start_o, stop_o, scl_rise_o, scl_fall_o, bit_o});
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if ({start_o, stop_o, scl_rise_o, scl_fall_o, bit_o} != 5'b0) begin
      n_fail++;
      $display("FAIL R1: after release actual %b expected 00000",
               {start_o, stop_o, scl_rise_o, scl_fall_o, bit_o});
    end
    running = 1'b1;
    drain("R1");

    // Plain transfer: start, two bits, stop (R2 R4 R5 R6 R3)
    expect_ev(EV_START, "R2"); drive(1, 0, SETTLE);
    expect_ev(EV_FALL, "R5");  drive(0, 0, SETTLE);
    drive(0, 1, SETTLE);
    expect_ev(EV_RISE1, "R4"); drive(1, 1, SETTLE);
    expect_ev(EV_FALL, "R5");  drive(0, 1, SETTLE);
    drive(0, 0, SETTLE);       // R6: data change with clock low
    drive(0, 1, SETTLE);
    drive(0, 0, SETTLE);
    expect_ev(EV_RISE0, "R4"); drive(1, 0, SETTLE);
    expect_ev(EV_FALL, "R5");  drive(0, 0, SETTLE);
    expect_ev(EV_RISE0, "R4"); drive(1, 0, SETTLE);
    expect_ev(EV_STOP, "R3");  drive(1, 1, SETTLE);
    drain("R3");

    // R7: glitches just below the limit are ignored
    drive(1, 0, FILT - 1); drive(1, 1, SETTLE);
    drive(0, 1, FILT - 1); drive(1, 1, SETTLE);
    drain("R7");
    // R7: pulse at the limit is accepted
    expect_ev(EV_START, "R7"); drive(1, 0, FILT);
    expect_ev(EV_STOP, "R7");  drive(1, 1, SETTLE);
    drain("R7");

    // R8: joint edges, repeated start, clock glitch while low
    expect_ev(EV_START, "R2"); drive(1, 0, SETTLE);
    expect_ev(EV_FALL, "R5");  drive(0, 0, SETTLE);
    drive(0, 1, SETTLE);
    expect_ev(EV_RISE1, "R4"); drive(1, 1, SETTLE);
    expect_ev(EV_FALL, "R8");  drive(0, 0, SETTLE);
    expect_ev(EV_RISE1, "R8"); drive(1, 1, SETTLE);
    expect_ev(EV_START, "R8"); drive(1, 0, SETTLE);
    expect_ev(EV_FALL, "R5");  drive(0, 0, SETTLE);
    drive(1, 0, FILT - 1);     // R7 clock glitch
    drive(0, 0, SETTLE);
    expect_ev(EV_RISE0, "R4"); drive(1, 0, SETTLE);
    expect_ev(EV_STOP, "R3");  drive(1, 1, SETTLE);
    drain("R8");

    // R10: recovery with nine dummy clocks then start and stop
    expect_ev(EV_START, "R10"); drive(1, 0, SETTLE);
    expect_ev(EV_FALL, "R10");  drive(0, 0, SETTLE);
    drive(0, 1, SETTLE);
    for (int i = 0; i < 9; i++) begin
      expect_ev(EV_RISE1, "R10"); drive(1, 1, SETTLE);
      expect_ev(EV_FALL, "R10");  drive(0, 1, SETTLE);
    end
    expect_ev(EV_RISE1, "R10"); drive(1, 1, SETTLE);
    expect_ev(EV_START, "R10"); drive(1, 0, SETTLE);
    expect_ev(EV_FALL, "R10");  drive(0, 0, SETTLE);
    expect_ev(EV_RISE0, "R10"); drive(1, 0, SETTLE);
    expect_ev(EV_STOP, "R10");  drive(1, 1, SETTLE);
    drain("R10");

    running = 1'b0;
    done    = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule